// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides which receive message buffers accept an incoming CAN frame identifier. Each of the sixteen buffers holds a programmed identifier, a format flag (standard or extended) and an enable bit. Three programmable acceptance masks control which identifier bits take part in the comparison. A global mask serves buffers 0 through 13. Buffers 14 and 15 each have a private mask. The same 29-bit mask layout is used for both 11-bit and 29-bit identifiers. For a standard frame only the upper 11 bits take part.

A receiver presents an identifier, its format flag and a one-cycle `idValid` strobe. One clock later the block presents a registered vector of matching buffers, the index of the lowest-numbered match, and a flag that is set when no buffer matched. Software programs masks and buffers through a simple write port. Mask writes take effect only while the configuration-mode input is high. This stops a mask from shifting under frames that are already in flight.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, `resultValid` is 0, `matchVec` is all zeros, `winIdx` is 0 and `noMatch` is 1. All masks reset to all ones and every buffer resets to disabled.
- R2: The result is registered. `matchVec`, `winIdx`, `noMatch` and a high `resultValid` appear in the cycle after `idValid` is sampled high. `resultValid` is low in any cycle that follows a cycle without `idValid`, and the result outputs then hold their last value.
- R3: A mask bit of 1 requires the incoming identifier bit to equal the buffer's identifier bit. A mask bit of 0 makes that bit don't-care.
- R4: Buffers 0 to 13 use the global mask at write address 0. Buffer 14 uses the private mask at address 1, and buffer 15 uses the private mask at address 2. In each case the mask value is `wrData[28:0]`.
- R5: For a standard frame (`rxExt`=0) only identifier bits 28 to 18 are compared. Bits 17 to 0 are ignored whatever the mask holds. For an extended frame all 29 bits are compared under the mask.
- R6: A buffer matches only if it is enabled and its format flag equals `rxExt`.
- R7: `matchVec` bit n is 1 when buffer n matches. `winIdx` is the lowest index whose bit is set. When no buffer matches, `noMatch` is 1 and `winIdx` is 0.
- R8: A mask write made while `cfgMode` is 0 is ignored. Buffer writes are accepted whatever the value of `cfgMode`.
- R9: A write to address 16+n (with `wrAddr[4]`=1 and `wrAddr[3:0]`=n) programs buffer n: `wrData[28:0]` is the identifier, `wrData[29]` is the format flag (1 means extended) and `wrData[30]` is the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgMode | input | 1 | Configuration mode; mask writes are accepted only while this is high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register write address |
| wrData | input | 31 | Register write data |
| idValid | input | 1 | Incoming identifier strobe |
| rxId | input | 29 | Incoming identifier; a standard identifier sits in bits 28:18 |
| rxExt | input | 1 | Incoming format flag, 1 means extended |
| matchVec | output | 16 | Registered per-buffer match vector |
| winIdx | output | 4 | Index of the lowest-numbered matching buffer |
| noMatch | output | 1 | High when no buffer matched |
| resultValid | output | 1 | High for one cycle after each `idValid` |

## Verification
Several buffers are set up to match one standard identifier at once, which tests the priority pick. Getting the encoder direction wrong would report the highest-numbered buffer instead of buffer 0. A standard probe carries junk in bits 17 to 0, and a buffer holds nonzero low bits. A filter that compared those bits for standard frames would then drop buffers that should match. Buffer 14 is given an identifier that differs from buffer 1 only in bits outside its private mask. Using the global mask there would lose the buffer-14 hit. A mask write made outside configuration mode must leave the next result unchanged, while a buffer write in that mode must show up as a new hit.

// File: rtl/can_accept_pkg.sv
package can_accept_pkg;

  typedef struct packed {
    logic       gMaskWe;
    logic [1:0] pMaskWe;
    logic       bufWe;
    logic       capture;
  } filt_strobe_t;

endpackage

// File: rtl/can_accept_ctrl.sv
module can_accept_ctrl
  import can_accept_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMode,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              idValid,
  output filt_strobe_t      strobe,
  output logic              resultValid
);

  logic              isBuf;
  logic [IDX_W-1:0]  lowAddr;

  assign isBuf   = wrAddr[IDX_W];
  assign lowAddr = wrAddr[IDX_W-1:0];

  always_comb begin
    strobe            = '0;
    strobe.capture    = idValid;
    strobe.bufWe      = wrEn && isBuf;
    if (wrEn && cfgMode && !isBuf) begin
      strobe.gMaskWe    = (lowAddr == IDX_W'(0));
      strobe.pMaskWe[0] = (lowAddr == IDX_W'(1));
      strobe.pMaskWe[1] = (lowAddr == IDX_W'(2));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= idValid;
  end

endmodule

// File: rtl/can_accept_dpath.sv
module can_accept_dpath
  import can_accept_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int ID_W    = 29,
  parameter int STD_W   = 11,
  parameter int IDX_W   = $clog2(NUM_BUF),
  parameter int DATA_W  = ID_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  filt_strobe_t       strobe,
  input  logic [IDX_W-1:0]   bufSel,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ID_W-1:0]    rxId,
  input  logic               rxExt,
  output logic [NUM_BUF-1:0] matchVec,
  output logic [IDX_W-1:0]   winIdx,
  output logic               noMatch
);

  localparam logic [ID_W-1:0] STD_KEEP = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

  logic [ID_W-1:0]    gMask;
  logic [ID_W-1:0]    pMask [2];
  logic [ID_W-1:0]    bufId [NUM_BUF];
  logic [NUM_BUF-1:0] bufExt;
  logic [NUM_BUF-1:0] bufEn;
  logic [NUM_BUF-1:0] hit;
  logic [IDX_W-1:0]   firstHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gMask    <= '1;
      pMask[0] <= '1;
      pMask[1] <= '1;
    end else begin
      if (strobe.gMaskWe)    gMask    <= wrData[ID_W-1:0];
      if (strobe.pMaskWe[0]) pMask[0] <= wrData[ID_W-1:0];
      if (strobe.pMaskWe[1]) pMask[1] <= wrData[ID_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BUF; i++) bufId[i] <= '0;
      bufExt <= '0;
      bufEn  <= '0;
    end else if (strobe.bufWe) begin
      bufId[bufSel]  <= wrData[ID_W-1:0];
      bufExt[bufSel] <= wrData[ID_W];
      bufEn[bufSel]  <= wrData[ID_W+1];
    end
  end

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_cmp
    logic [ID_W-1:0] selMask;
    logic [ID_W-1:0] effMask;
    if (b == NUM_BUF - 2) begin : g_priv0
      assign selMask = pMask[0];
    end else if (b == NUM_BUF - 1) begin : g_priv1
      assign selMask = pMask[1];
    end else begin : g_glob
      assign selMask = gMask;
    end
    assign effMask = rxExt ? selMask : (selMask & STD_KEEP);
    assign hit[b]  = bufEn[b] && (bufExt[b] == rxExt) &&
                     (((rxId ^ bufId[b]) & effMask) == '0);
  end

  always_comb begin
    firstHit = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (hit[i]) firstHit = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchVec <= '0;
      winIdx   <= '0;
      noMatch  <= 1'b1;
    end else if (strobe.capture) begin
      matchVec <= hit;
      winIdx   <= firstHit;
      noMatch  <= (hit == '0);
    end
  end

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_accept_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int ID_W    = 29,
  parameter int STD_W   = 11,
  localparam int IDX_W  = $clog2(NUM_BUF),
  localparam int ADDR_W = IDX_W + 1,
  localparam int DATA_W = ID_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgMode,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               idValid,
  input  logic [ID_W-1:0]    rxId,
  input  logic               rxExt,
  output logic [NUM_BUF-1:0] matchVec,
  output logic [IDX_W-1:0]   winIdx,
  output logic               noMatch,
  output logic               resultValid
);

  filt_strobe_t strobe;

  can_accept_ctrl #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .wrEn(wrEn), .wrAddr(wrAddr),
    .idValid(idValid), .strobe(strobe), .resultValid(resultValid)
  );

  can_accept_dpath #(.NUM_BUF(NUM_BUF), .ID_W(ID_W), .STD_W(STD_W),
                     .IDX_W(IDX_W), .DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bufSel(wrAddr[IDX_W-1:0]),
    .wrData(wrData), .rxId(rxId), .rxExt(rxExt),
    .matchVec(matchVec), .winIdx(winIdx), .noMatch(noMatch)
  );

endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk #(
  parameter int NUM_BUF = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               idValid,
  input logic [NUM_BUF-1:0] matchVec,
  input logic [IDX_W-1:0]   winIdx,
  input logic               noMatch,
  input logic               resultValid
);

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    idValid |=> resultValid); // R2

  AST_NO_VALID_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !idValid |=> !resultValid); // R2

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !idValid |=> ($stable(matchVec) && $stable(winIdx) && $stable(noMatch))); // R2

  AST_NOMATCH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (noMatch == (matchVec == '0))); // R7

  AST_WINNER_SET: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !noMatch) |-> matchVec[winIdx]); // R7

  AST_WINNER_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !noMatch) |->
      ((matchVec & ((NUM_BUF'(1) << winIdx) - NUM_BUF'(1))) == '0)); // R7

  AST_IDLE_WINNER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && noMatch) |-> (winIdx == '0)); // R7

endmodule

bind can_accept_filter can_accept_filter_chk #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rstN(rstN), .idValid(idValid), .matchVec(matchVec),
  .winIdx(winIdx), .noMatch(noMatch), .resultValid(resultValid)
);

// File: tb/test_can_accept_filter.sv
module test_can_accept_filter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgMode = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [30:0] wrData = '0;
  logic        idValid = 1'b0;
  logic [28:0] rxId = '0;
  logic        rxExt = 1'b0;
  logic [15:0] matchVec;
  logic [3:0]  winIdx;
  logic        noMatch;
  logic        resultValid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  can_accept_filter i_can_accept_filter (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .idValid(idValid), .rxId(rxId), .rxExt(rxExt),
    .matchVec(matchVec), .winIdx(winIdx), .noMatch(noMatch),
    .resultValid(resultValid)
  );

  typedef struct packed {
    logic [28:0] id;
    logic        ext;
    logic [15:0] vec;
    logic [3:0]  win;
    logic        none;
  } vec_t;

  localparam logic [28:0] STD_A5 = 29'h0A5 << 18;

  localparam vec_t VECS [7] = '{
    '{STD_A5,                  1'b0, 16'h8021, 4'd0,  1'b0},
    '{29'h12345678,            1'b1, 16'h4002, 4'd1,  1'b0},
    '{29'h12345679,            1'b1, 16'h4000, 4'd14, 1'b0},
    '{STD_A5,                  1'b1, 16'h0004, 4'd2,  1'b0},
    '{STD_A5 | 29'h1,          1'b1, 16'h0000, 4'd0,  1'b1},
    '{29'h1FFC0000,            1'b0, 16'h8000, 4'd15, 1'b0},
    '{STD_A5 | 29'h3FFFF,      1'b0, 16'h8021, 4'd0,  1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [30:0] d, input logic cfg);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; cfgMode = cfg;
    @(negedge clk);
    wrEn = 1'b0; cfgMode = 1'b0;
  endtask

  task automatic probe(input logic [28:0] id, input logic ext,
                       input logic [15:0] eVec, input logic [3:0] eWin,
                       input logic eNone, input string req);
    @(negedge clk);
    idValid = 1'b1; rxId = id; rxExt = ext;
    @(negedge clk);
    idValid = 1'b0;
    check({req, " valid"}, {31'b0, resultValid}, 32'd1);
    check({req, " matchVec"}, {16'b0, matchVec}, {16'b0, eVec});
    check({req, " winIdx"}, {28'b0, winIdx}, {28'b0, eWin});
    check({req, " noMatch"}, {31'b0, noMatch}, {31'b0, eNone});
  endtask

  function automatic logic [30:0] bufWord(input logic en, input logic ext, input logic [28:0] id);
    return {en, ext, id};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {31'b0, resultValid}, 32'd0);
    check("R1 matchVec", {16'b0, matchVec}, 32'd0);
    check("R1 winIdx", {28'b0, winIdx}, 32'd0);
    check("R1 noMatch", {31'b0, noMatch}, 32'd1);
    rstN = 1'b1;
    // R1: buffers reset disabled, so nothing matches
    probe(29'h0, 1'b0, 16'h0000, 4'd0, 1'b1, "R1 disabled");

    // R4 R9: program masks and buffers
    wr(5'd1, {2'b0, 29'h1FFC0000}, 1'b1);
    wr(5'd2, 31'h0, 1'b1);
    wr(5'd16, bufWord(1'b1, 1'b0, STD_A5), 1'b0);
    wr(5'd17, bufWord(1'b1, 1'b1, 29'h12345678), 1'b0);
    wr(5'd18, bufWord(1'b1, 1'b1, STD_A5), 1'b0);
    wr(5'd19, bufWord(1'b0, 1'b0, STD_A5), 1'b0);
    wr(5'd21, bufWord(1'b1, 1'b0, STD_A5 | 29'h3), 1'b0);
    wr(5'd30, bufWord(1'b1, 1'b1, 29'h12345678), 1'b0);
    wr(5'd31, bufWord(1'b1, 1'b0, 29'h0), 1'b0);

    // Table walk: R3 R4 R5 R6 R7
    for (int k = 0; k < 7; k++) begin
      probe(VECS[k].id, VECS[k].ext, VECS[k].vec, VECS[k].win, VECS[k].none,
            $sformatf("R3/R4/R5/R6/R7 vec%0d", k));
    end

    // R2: no strobe, so valid drops and the result holds
    @(negedge clk);
    check("R2 valid low", {31'b0, resultValid}, 32'd0);
    check("R2 hold", {16'b0, matchVec}, 32'h8021);
    rxId = 29'h0; rxExt = 1'b1;
    @(negedge clk);
    check("R2 hold after input change", {16'b0, matchVec}, 32'h8021);

    // R8: global mask write outside config mode is ignored
    wr(5'd0, 31'h0, 1'b0);
    probe(STD_A5 | 29'h1, 1'b1, 16'h0000, 4'd0, 1'b1, "R8 mask locked");
    // R8: buffer write outside config mode is accepted
    wr(5'd19, bufWord(1'b1, 1'b0, STD_A5), 1'b0);
    probe(STD_A5, 1'b0, 16'h8029, 4'd0, 1'b0, "R8 buffer write");
    // R8 R3: mask write in config mode takes effect
    wr(5'd0, 31'h0, 1'b1);
    probe(STD_A5 | 29'h1, 1'b1, 16'h0006, 4'd1, 1'b0, "R8 mask written");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule